// File: doc/BRIEF.md
# Self-Routing Delta Switch Fabric

This block is an N-by-N packet fabric. N is a power of two and defaults to 8. It is built from log2(N) stages. Each stage holds N/2 two-by-two switching elements. Every element keeps exactly one packet slot for each of its two inputs.

A packet has three fields:
- a destination index;
- a one-bit priority (1 = high, 0 = low);
- a payload.

The packet finds its own way to the addressed output. At stage s it reads one bit of the destination, bit log2(N)-1-s, so the most significant bit is used first. A value of 0 sends it to the element's upper output, and 1 sends it to the lower output. Between stages, and in front of the first stage, lines are rewired by a perfect shuffle (a one-bit left rotation of the line index). This leaves exactly one path between any input and any output, and the path ends on the output whose index equals the destination.

All elements advance together on one clock, and a packet moves forward by at most one stage per cycle. Flow control works as follows:
- A packet moves forward only when the slot ahead is empty, or is being emptied in the same cycle.
- This readiness travels combinationally from the outputs back to the inputs within the cycle.
- The outputs always take what is presented, so the last stage never stalls.
- A packet offered at an input whose first-stage slot cannot take it is thrown away, and the fabric flags the drop.

Top module: `dn_fabric`

## Requirements
- R1: Synchronous active-high reset empties every slot. In the cycle after reset is released, no output is valid. A packet that was inside the fabric when reset was asserted never appears at any output.
- R2: A packet offered with destination index d appears only at output d. It keeps its priority bit and payload unchanged, and it appears exactly once.
- R3: With no contention, a packet offered in a cycle is valid at its output right after the n-th rising edge that follows, where n = log2(N), and it is valid for exactly that one cycle.
- R4: In the cycle it is offered, an input packet is accepted (accept high, drop low) when its first-stage slot is empty or is sending its packet onward in that cycle. Otherwise drop is high and accept is low, and the packet never reaches any output.
- R5: When both slots of one element need the same element output, a high-priority packet (priority bit 1) goes before a low-priority one. Between equal priorities, the slot on the element's upper input (even line) goes first.
- R6: A packet that loses arbitration stays in its slot unchanged and moves on in a later cycle. It is not lost.
- R7: A conflict-free permutation offered on all N inputs in consecutive cycles is accepted on every input each cycle. It leaves on all N outputs in consecutive cycles, because the outputs never stall.
- R8: Packets from one input to one output leave in the order they were accepted. Back-to-back packets of such a flow leave in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | A packet is offered on each input whose bit is set |
| in_hi | input | N | Priority bit of each offered packet, 1 = high |
| in_dst | input | N x log2(N) | Destination output index of each offered packet |
| in_data | input | N x DATA_W | Payload of each offered packet |
| in_accept | output | N | Offered packet is taken into the first stage this cycle |
| in_drop | output | N | Offered packet is discarded because its first-stage slot is occupied |
| out_valid | output | N | A packet leaves on this output in this cycle |
| out_hi | output | N | Priority bit of the leaving packet |
| out_data | output | N x DATA_W | Payload of the leaving packet |

## Verification
Single packets are sent for every source and destination pair, and for a table of chosen vectors. These runs separate wiring and tag-bit mistakes, which show up on the wrong output, from latency mistakes, which show up in the wrong cycle. Two inputs that share a first-stage element are then aimed at the same element output with mixed and with equal priorities. This tells the priority rule apart from the tie rule, and it creates a full, non-departing slot that must drop a new arrival while its departing neighbour accepts one. Back-to-back packets on one flow expose reordering or bubbles. Two conflict-free full-load permutations in consecutive cycles expose any stall on the ready chain. A reset in mid-flight shows that buffered packets are cleared.

// File: rtl/dn_pkg.sv
package dn_pkg;

    parameter int unsigned FAB_PORTS = 8;
    parameter int unsigned DATA_W    = 8;

    localparam int unsigned ADDR_W     = $clog2(FAB_PORTS);
    localparam int unsigned N_STAGES   = ADDR_W;
    localparam int unsigned ELEMS_PER_STAGE = FAB_PORTS / 2;

    typedef struct packed {
        logic              hi;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } cell_t;

    // perfect shuffle: rotate the line index left by one
    function automatic logic [ADDR_W-1:0] shuffle(input logic [ADDR_W-1:0] idx);
        return (idx << 1) | (idx >> (ADDR_W - 1));
    endfunction

    // inverse shuffle: rotate right by one
    function automatic logic [ADDR_W-1:0] unshuffle(input logic [ADDR_W-1:0] idx);
        return (idx >> 1) | (idx << (ADDR_W - 1));
    endfunction

endpackage

// File: rtl/dn_elem.sv
module dn_elem
    import dn_pkg::*;
#(
    parameter int unsigned ROUTE_BIT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  up_vld,
    input  cell_t [1:0] up_cell,
    output logic [1:0]  up_rdy,
    output logic [1:0]  dn_vld,
    output cell_t [1:0] dn_cell,
    input  logic [1:0]  dn_rdy
);

    cell_t [1:0] slot_q;
    logic  [1:0] full_q;
    logic  [1:0] want;
    logic  [1:0] grant;
    logic  [1:0] leave;
    logic        clash;
    logic        favour_low;

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            want[i] = slot_q[i].dst[ROUTE_BIT];
        end
        clash      = full_q[0] && full_q[1] && (want[0] == want[1]);
        favour_low = slot_q[1].hi && !slot_q[0].hi;
        grant[0]   = full_q[0] && !(clash && favour_low);
        grant[1]   = full_q[1] && !(clash && !favour_low);

        dn_vld  = '0;
        dn_cell = '0;
        for (int i = 0; i < 2; i++) begin
            if (grant[i]) begin
                dn_vld[want[i]]  = 1'b1;
                dn_cell[want[i]] = slot_q[i];
            end
        end
        for (int i = 0; i < 2; i++) begin
            leave[i]  = grant[i] && dn_rdy[want[i]];
            up_rdy[i] = !full_q[i] || leave[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
            slot_q <= '0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (up_vld[i] && up_rdy[i]) begin
                    full_q[i] <= 1'b1;
                    slot_q[i] <= up_cell[i];
                end else if (leave[i]) begin
                    full_q[i] <= 1'b0;
                end
            end
        end
    end

    // each element output only carries packets whose tag bit selects it (R2)
    p_route_upper_r2: assert property (@(posedge clk) disable iff (rst)
        dn_vld[0] |-> (dn_cell[0].dst[ROUTE_BIT] == 1'b0));
    p_route_lower_r2: assert property (@(posedge clk) disable iff (rst)
        dn_vld[1] |-> (dn_cell[1].dst[ROUTE_BIT] == 1'b1));

    // a high-priority packet is presented first on a contended output (R5)
    p_high_first_r5: assert property (@(posedge clk) disable iff (rst)
        (full_q[0] && full_q[1] && (want[0] == want[1]) && (slot_q[0].hi || slot_q[1].hi))
        |-> dn_cell[want[0]].hi);

    // a slot that could not hand on its packet keeps it unchanged (R6)
    for (genvar i = 0; i < 2; i++) begin : g_hold
        p_hold_blocked_r6: assert property (@(posedge clk) disable iff (rst)
            (full_q[i] && !up_rdy[i]) |=> (full_q[i] && $stable(slot_q[i])));
    end

endmodule

// File: rtl/dn_stage.sv
module dn_stage
    import dn_pkg::*;
#(
    parameter int unsigned STAGE = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FAB_PORTS-1:0]  up_vld,
    input  cell_t [FAB_PORTS-1:0] up_cell,
    output logic [FAB_PORTS-1:0]  up_rdy,
    output logic [FAB_PORTS-1:0]  dn_vld,
    output cell_t [FAB_PORTS-1:0] dn_cell,
    input  logic [FAB_PORTS-1:0]  dn_rdy
);

    localparam int unsigned ROUTE_BIT = ADDR_W - 1 - STAGE;

    for (genvar e = 0; e < ELEMS_PER_STAGE; e++) begin : g_elem
        dn_elem #(
            .ROUTE_BIT(ROUTE_BIT)
        ) u_elem (
            .clk     (clk),
            .rst     (rst),
            .up_vld  (up_vld[2*e+1:2*e]),
            .up_cell (up_cell[2*e+1:2*e]),
            .up_rdy  (up_rdy[2*e+1:2*e]),
            .dn_vld  (dn_vld[2*e+1:2*e]),
            .dn_cell (dn_cell[2*e+1:2*e]),
            .dn_rdy  (dn_rdy[2*e+1:2*e])
        );
    end

endmodule

// File: rtl/dn_fabric.sv
module dn_fabric
    import dn_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [FAB_PORTS-1:0]             in_valid,
    input  logic [FAB_PORTS-1:0]             in_hi,
    input  logic [FAB_PORTS-1:0][ADDR_W-1:0] in_dst,
    input  logic [FAB_PORTS-1:0][DATA_W-1:0] in_data,
    output logic [FAB_PORTS-1:0]             in_accept,
    output logic [FAB_PORTS-1:0]             in_drop,
    output logic [FAB_PORTS-1:0]             out_valid,
    output logic [FAB_PORTS-1:0]             out_hi,
    output logic [FAB_PORTS-1:0][DATA_W-1:0] out_data
);

    localparam int unsigned LAST = N_STAGES - 1;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stg
        logic [FAB_PORTS-1:0]  i_vld;
        logic [FAB_PORTS-1:0]  i_rdy;
        logic [FAB_PORTS-1:0]  o_vld;
        logic [FAB_PORTS-1:0]  o_rdy;
        cell_t [FAB_PORTS-1:0] i_cell;
        cell_t [FAB_PORTS-1:0] o_cell;

        if (s == 0) begin : g_head
            always_comb begin
                logic [ADDR_W-1:0] src;
                i_vld  = '0;
                i_cell = '0;
                for (int p = 0; p < FAB_PORTS; p++) begin
                    src       = unshuffle(ADDR_W'(p));
                    i_vld[p]  = in_valid[src];
                    i_cell[p] = '{hi: in_hi[src], dst: in_dst[src], data: in_data[src]};
                end
            end
        end else begin : g_link
            always_comb begin
                logic [ADDR_W-1:0] src;
                i_vld  = '0;
                i_cell = '0;
                for (int p = 0; p < FAB_PORTS; p++) begin
                    src       = unshuffle(ADDR_W'(p));
                    i_vld[p]  = g_stg[s-1].o_vld[src];
                    i_cell[p] = g_stg[s-1].o_cell[src];
                end
            end
        end

        if (s == LAST) begin : g_sink
            assign o_rdy = '1;
        end else begin : g_back
            always_comb begin
                o_rdy = '0;
                for (int l = 0; l < FAB_PORTS; l++) begin
                    o_rdy[l] = g_stg[s+1].i_rdy[shuffle(ADDR_W'(l))];
                end
            end
        end

        dn_stage #(
            .STAGE(s)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .up_vld  (i_vld),
            .up_cell (i_cell),
            .up_rdy  (i_rdy),
            .dn_vld  (o_vld),
            .dn_cell (o_cell),
            .dn_rdy  (o_rdy)
        );
    end

    always_comb begin
        for (int l = 0; l < FAB_PORTS; l++) begin
            in_accept[l] = in_valid[l] &&  g_stg[0].i_rdy[shuffle(ADDR_W'(l))];
            in_drop[l]   = in_valid[l] && !g_stg[0].i_rdy[shuffle(ADDR_W'(l))];
            out_valid[l] = g_stg[LAST].o_vld[l];
            out_hi[l]    = g_stg[LAST].o_cell[l].hi;
            out_data[l]  = g_stg[LAST].o_cell[l].data;
        end
    end

    // nothing leaves in the first cycle after reset (R1)
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0));

    // an input never reports accept and drop together, nor either one while idle (R4)
    p_ingress_flags_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({in_accept[0], in_drop[0]}) == 32'(in_valid[0]));

endmodule

// File: tb/tb_dn_fabric.sv
`timescale 1ns/1ps
module tb_dn_fabric;
    import dn_pkg::*;

    localparam int NP = FAB_PORTS;
    localparam int NS = N_STAGES;

    typedef struct packed {
        int unsigned src;
        int unsigned dst;
        int unsigned hi;
        int unsigned data;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{0, 0, 0, 8'h01}, '{0, 7, 1, 8'hA5}, '{7, 0, 0, 8'h5A},
        '{7, 7, 1, 8'hFF}, '{3, 4, 0, 8'h34}, '{4, 3, 1, 8'h43},
        '{1, 6, 0, 8'h16}, '{6, 1, 1, 8'h61}, '{2, 5, 1, 8'h25},
        '{5, 2, 0, 8'h52}, '{3, 3, 0, 8'h00}, '{6, 6, 1, 8'h66}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NP-1:0]            in_valid;
    logic [NP-1:0]            in_hi;
    logic [NP-1:0][ADDR_W-1:0] in_dst;
    logic [NP-1:0][DATA_W-1:0] in_data;
    logic [NP-1:0]            in_accept;
    logic [NP-1:0]            in_drop;
    logic [NP-1:0]            out_valid;
    logic [NP-1:0]            out_hi;
    logic [NP-1:0][DATA_W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dn_fabric dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_hi     (in_hi),
        .in_dst    (in_dst),
        .in_data   (in_data),
        .in_accept (in_accept),
        .in_drop   (in_drop),
        .out_valid (out_valid),
        .out_hi    (out_hi),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        in_valid = '0;
        in_hi    = '0;
        in_dst   = '0;
        in_data  = '0;
    endtask

    task automatic drive(input int src, input int dst, input bit hi, input int data);
        in_valid[src] = 1'b1;
        in_hi[src]    = hi;
        in_dst[src]   = ADDR_W'(dst);
        in_data[src]  = DATA_W'(data);
    endtask

    task automatic expect_none(input string req);
        chk(out_valid == '0, req, "no output", out_valid, 0);
    endtask

    task automatic expect_one(input int port, input int data, input bit hi, input string req);
        logic [NP-1:0] m;
        m = '0;
        m[port] = 1'b1;
        chk(out_valid == m, req, "valid mask", out_valid, m);
        chk(out_data[port] == DATA_W'(data), req, "payload", out_data[port], data);
        chk(out_hi[port] == hi, req, "priority", out_hi[port], hi);
    endtask

    // lone packet: accepted, silent for n-1 edges, on its output after edge n, then gone
    task automatic send_single(input int src, input int dst, input bit hi, input int data);
        idle();
        drive(src, dst, hi, data);
        #1;
        chk(in_accept[src] && !in_drop[src], "R4", "lone accept", in_accept[src], 1);
        tick();
        idle();
        for (int k = 1; k <= NS + 1; k++) begin
            if (k > 1) tick();
            if (k == NS) expect_one(dst, data, hi, "R2");
            else         expect_none("R3");
        end
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        expect_none("R1");

        // R1: a packet in flight is cleared by reset
        drive(1, 4, 1'b1, 8'hC3);
        tick();
        idle();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        for (int k = 0; k < NS + 2; k++) begin
            tick();
            expect_none("R1");
        end

        // table walk: R2 routing and R3 latency
        for (int v = 0; v < NVEC; v++) begin
            send_single(int'(VECS[v].src), int'(VECS[v].dst), VECS[v].hi[0], int'(VECS[v].data));
        end

        // every source to every destination
        for (int s = 0; s < NP; s++) begin
            for (int d = 0; d < NP; d++) begin
                send_single(s, d, 1'((s + d) % 2), (s * 16 + d) & 8'hFF);
            end
        end

        // R5/R4/R6: inputs 0 and 4 share a first-stage element
        idle();
        drive(0, 5, 1'b0, 8'h11);
        drive(4, 5, 1'b1, 8'h22);
        #1;
        chk(in_accept[0] && in_accept[4], "R4", "both empty slots accept", {in_accept[4], in_accept[0]}, 3);
        tick();
        idle();
        drive(0, 2, 1'b0, 8'h33);
        drive(4, 6, 1'b0, 8'h44);
        #1;
        chk(in_drop[0] && !in_accept[0], "R4", "held slot drops", {in_accept[0], in_drop[0]}, 1);
        chk(in_accept[4] && !in_drop[4], "R4", "departing slot accepts", {in_accept[4], in_drop[4]}, 2);
        tick();
        idle();
        expect_none("R5");
        tick(); expect_one(5, 8'h22, 1'b1, "R5");
        tick(); expect_one(5, 8'h11, 1'b0, "R6");
        tick(); expect_one(6, 8'h44, 1'b0, "R5");
        tick(); expect_none("R4");
        tick(); expect_none("R4");

        // R5 tie: equal priority, upper element input wins
        drive(0, 1, 1'b1, 8'h77);
        drive(4, 3, 1'b1, 8'h88);
        tick();
        idle();
        tick(); expect_none("R5");
        tick(); expect_one(1, 8'h77, 1'b1, "R5");
        tick(); expect_one(3, 8'h88, 1'b1, "R6");
        tick(); expect_none("R5");

        // R8: three packets back to back on one flow
        drive(2, 7, 1'b0, 8'h81);
        tick();
        drive(2, 7, 1'b1, 8'h82);
        #1;
        chk(in_accept[2], "R8", "second accept", in_accept[2], 1);
        tick();
        drive(2, 7, 1'b0, 8'h83);
        #1;
        chk(in_accept[2], "R8", "third accept", in_accept[2], 1);
        tick();
        idle();
        expect_one(7, 8'h81, 1'b0, "R8");
        tick(); expect_one(7, 8'h82, 1'b1, "R8");
        tick(); expect_one(7, 8'h83, 1'b0, "R8");
        tick(); expect_none("R8");

        // R7: two conflict-free permutations at full load
        for (int i = 0; i < NP; i++) drive(i, i, 1'(i % 2), 8'h10 + i);
        #1;
        chk(in_accept == '1, "R7", "wave one accepts", in_accept, '1);
        tick();
        idle();
        for (int i = 0; i < NP; i++) drive(i, i ^ (NP - 1), 1'b0, 8'h20 + i);
        #1;
        chk(in_accept == '1, "R7", "wave two accepts", in_accept, '1);
        tick();
        idle();
        tick();
        chk(out_valid == '1, "R7", "wave one mask", out_valid, '1);
        for (int j = 0; j < NP; j++) begin
            chk(out_data[j] == DATA_W'(8'h10 + j), "R7", "wave one payload", out_data[j], 8'h10 + j);
        end
        tick();
        chk(out_valid == '1, "R7", "wave two mask", out_valid, '1);
        for (int j = 0; j < NP; j++) begin
            chk(out_data[j] == DATA_W'(8'h20 + (j ^ (NP - 1))), "R7", "wave two payload",
                out_data[j], 8'h20 + (j ^ (NP - 1)));
        end
        tick();
        expect_none("R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule